// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog timer with three byte-wide registers on a simple synchronous read/write bus. Software writes a nonzero count to the timeout register. That write arms a down-counter, and the counter is decremented once per time unit. A prescaler makes each unit either one second or sixty seconds. The number of clock cycles in one second is a parameter. Writing zero to the timeout register stops the watchdog.

When the count runs out, the block raises a one-cycle fire event and sets a sticky fired flag. If the control register routes the event to the pin, it also drives an active-low keyboard-reset output for a parameterized number of cycles. Three other inputs can act on the counter. Mouse and keyboard interrupt pulses can restart the count from the last written value. A keyboard-controller line can force a timeout. A self-clearing status bit can also force a timeout. While the fired flag is set, no further timeout can fire. An interrupt-source select code held in the status register is presented on an output port.

Top module: `pwdog_top`

## Requirements
- R1: After reset the control (address 0), timeout (address 1) and status (address 2) registers all read 0, `wdt_fire` is low and `kbd_rst_n` is high. A read returns data on `bus_rdata` one cycle after the read strobe.
- R2: Writing a nonzero value N to the timeout register arms the watchdog. With control bit 3 clear, `wdt_fire` pulses exactly N·CLKS_PER_SEC cycles after the write edge.
- R3: With control bit 3 set, each count lasts 60·CLKS_PER_SEC cycles.
- R4: Writing 0 to the timeout register stops the counter. No fire follows, and the register reads 0.
- R5: While the watchdog is armed, reading the timeout register returns the remaining count.
- R6: With status bit 7 set, a mouse interrupt pulse on an armed counter restarts it from the last written timeout. With the bit clear, the pulse has no effect.
- R7: With status bit 6 set, a keyboard interrupt pulse on an armed counter restarts it the same way. With the bit clear, the pulse has no effect.
- R8: Writing 1 to status bit 5 fires at that write edge. The bit always reads 0.
- R9: Status bit 4 reads 1 from the fire edge onwards. Writing 0 to it clears it, and writing 1 leaves it unchanged. While it is set, no fire of any kind occurs.
- R10: With control bit 2 set, a high `kbc_p20` fires on the edge after it is seen. With the bit clear, `kbc_p20` is ignored.
- R11: With control bit 1 set, a fire drives `kbd_rst_n` low for exactly PULSE_CYCLES cycles, starting at the fire edge. With the bit clear, the pin stays high.
- R12: `irq_code` equals status bits 3:0, and `wdt_fire` is high for a single cycle per fire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| mouse_irq | input | 1 | Mouse interrupt pulse |
| kbd_irq | input | 1 | Keyboard interrupt pulse |
| kbc_p20 | input | 1 | Keyboard-controller force line |
| wdt_fire | output | 1 | One-cycle fire event |
| kbd_rst_n | output | 1 | Active-low keyboard-reset pulse |
| irq_code | output | 4 | Interrupt-source select code |

## Verification
On every cycle, the assertions check several properties. The fire event lasts exactly one cycle and always comes with the fired flag. A set flag suppresses any new fire. The counter never moves by more than one step unless there is a timeout write or an interrupt reload. The reset pin falls only when routing was enabled. Other behaviour can only be shown by the bench's scenarios: the exact fire latency for each unit and count, the reload timing from the two interrupt inputs, the readback of the remaining count, and the exact width of the reset pulse.

// File: rtl/pwdog_pkg.sv
package pwdog_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] ADR_TMO  = 2'd1;
  localparam logic [ADDR_W-1:0] ADR_STAT = 2'd2;

  // control register bit positions
  localparam int CB_UNIT60 = 3;
  localparam int CB_P20EN  = 2;
  localparam int CB_ROUTE  = 1;

  // status register bit positions
  localparam int SB_MOUSE = 7;
  localparam int SB_KBD   = 6;
  localparam int SB_FORCE = 5;
  localparam int SB_FIRED = 4;

  localparam int LONG_UNIT_SECS = 60;

  typedef struct packed {
    logic mouse_en;
    logic kbd_en;
    logic [3:0] irq_sel;
  } stat_cfg_t;
endpackage

// File: rtl/pwdog_regs.sv
module pwdog_regs
  import pwdog_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] cur_count,
  input  logic              fired,
  output logic [DATA_W-1:0] ctrl_q,
  output stat_cfg_t         scfg,
  output logic [DATA_W-1:0] tmo_last,
  output logic              tmo_wr,
  output logic              force_req,
  output logic              fired_clr,
  output logic [DATA_W-1:0] rdata
);
  logic stat_wr;

  assign tmo_wr    = bus_wr && (bus_addr == ADR_TMO);
  assign stat_wr   = bus_wr && (bus_addr == ADR_STAT);
  assign force_req = stat_wr && bus_wdata[SB_FORCE];
  assign fired_clr = stat_wr && !bus_wdata[SB_FIRED];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q   <= '0;
      scfg     <= '0;
      tmo_last <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        ADR_CTRL: ctrl_q <= bus_wdata;
        ADR_TMO:  tmo_last <= bus_wdata;
        ADR_STAT: begin
          scfg.mouse_en <= bus_wdata[SB_MOUSE];
          scfg.kbd_en   <= bus_wdata[SB_KBD];
          scfg.irq_sel  <= bus_wdata[3:0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        ADR_CTRL: rdata <= ctrl_q;
        ADR_TMO:  rdata <= cur_count;
        ADR_STAT: rdata <= {scfg.mouse_en, scfg.kbd_en, 1'b0, fired, scfg.irq_sel};
        default:  rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pwdog_prescale.sv
module pwdog_prescale #(
  parameter int CLKS_PER_SEC = 125_000_000,
  parameter int LONG_SECS    = 60
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic run,
  input  logic unit60,
  output logic unit_tick
);
  localparam int SW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam int MW = (LONG_SECS > 1) ? $clog2(LONG_SECS) : 1;

  logic [SW-1:0] sec_cnt;
  logic [MW-1:0] min_cnt;
  logic          sec_wrap;

  assign sec_wrap  = run && (sec_cnt == SW'(CLKS_PER_SEC - 1));
  assign unit_tick = sec_wrap && (!unit60 || (min_cnt == MW'(LONG_SECS - 1)));

  always_ff @(posedge clk) begin
    if (rst || restart || !run) begin
      sec_cnt <= '0;
      min_cnt <= '0;
    end else if (sec_wrap) begin
      sec_cnt <= '0;
      min_cnt <= unit_tick ? '0 : min_cnt + 1'b1;
    end else begin
      sec_cnt <= sec_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/pwdog_core.sv
module pwdog_core #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tmo_wr,
  input  logic [DW-1:0] tmo_val,
  input  logic [DW-1:0] tmo_last,
  input  logic          reload_req,
  input  logic          unit_tick,
  input  logic          force_req,
  input  logic          p20_fire,
  input  logic          fired_clr,
  output logic [DW-1:0] count,
  output logic          armed,
  output logic          restart,
  output logic          fire_now,
  output logic          fired,
  output logic          fire_evt
);
  logic reload_hit;
  logic expire;

  assign armed      = (count != '0);
  assign reload_hit = armed && reload_req;
  assign restart    = tmo_wr || reload_hit;
  assign expire     = unit_tick && (count == DW'(1));
  assign fire_now   = !fired && (force_req || p20_fire || expire);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (fire_now) begin
      count <= '0;
    end else if (tmo_wr) begin
      count <= tmo_val;
    end else if (reload_hit) begin
      count <= tmo_last;
    end else if (unit_tick && armed) begin
      count <= count - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fired    <= 1'b0;
      fire_evt <= 1'b0;
    end else begin
      fire_evt <= fire_now;
      if (fire_now)       fired <= 1'b1;
      else if (fired_clr) fired <= 1'b0;
    end
  end
endmodule

// File: rtl/pwdog_pulse.sv
module pwdog_pulse #(
  parameter int PULSE_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trigger,
  output logic pin_n
);
  localparam int PW = $clog2(PULSE_CYCLES + 1);

  logic [PW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left  <= '0;
      pin_n <= 1'b1;
    end else if (trigger) begin
      left  <= PW'(PULSE_CYCLES - 1);
      pin_n <= 1'b0;
    end else if (left != '0) begin
      left <= left - 1'b1;
    end else begin
      pin_n <= 1'b1;
    end
  end
endmodule

// File: rtl/pwdog_top.sv
module pwdog_top
  import pwdog_pkg::*;
#(
  parameter int CLKS_PER_SEC = 125_000_000,
  parameter int PULSE_CYCLES = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic        mouse_irq,
  input  logic        kbd_irq,
  input  logic        kbc_p20,
  output logic        wdt_fire,
  output logic        kbd_rst_n,
  output logic [3:0]  irq_code
);
  logic [DATA_W-1:0] ctrl_q;
  stat_cfg_t         scfg;
  logic [DATA_W-1:0] tmo_last;
  logic [DATA_W-1:0] count;
  logic              tmo_wr, force_req, fired_clr;
  logic              armed, restart, fire_now, fired;
  logic              unit_tick, reload_req, p20_fire, route_en;

  assign route_en   = ctrl_q[CB_ROUTE];
  assign p20_fire   = ctrl_q[CB_P20EN] && kbc_p20;
  assign reload_req = (scfg.mouse_en && mouse_irq) || (scfg.kbd_en && kbd_irq);
  assign irq_code   = scfg.irq_sel;

  pwdog_regs u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cur_count(count),
    .fired(fired), .ctrl_q(ctrl_q), .scfg(scfg), .tmo_last(tmo_last),
    .tmo_wr(tmo_wr), .force_req(force_req), .fired_clr(fired_clr),
    .rdata(bus_rdata)
  );

  pwdog_prescale #(.CLKS_PER_SEC(CLKS_PER_SEC), .LONG_SECS(LONG_UNIT_SECS)) u_pre (
    .clk(clk), .rst(rst), .restart(restart), .run(armed),
    .unit60(ctrl_q[CB_UNIT60]), .unit_tick(unit_tick)
  );

  pwdog_core #(.DW(DATA_W)) u_core (
    .clk(clk), .rst(rst), .tmo_wr(tmo_wr), .tmo_val(bus_wdata),
    .tmo_last(tmo_last), .reload_req(reload_req), .unit_tick(unit_tick),
    .force_req(force_req), .p20_fire(p20_fire), .fired_clr(fired_clr),
    .count(count), .armed(armed), .restart(restart), .fire_now(fire_now),
    .fired(fired), .fire_evt(wdt_fire)
  );

  pwdog_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
    .clk(clk), .rst(rst), .trigger(fire_now && route_en), .pin_n(kbd_rst_n)
  );
endmodule

// File: rtl/pwdog_checker.sv
module pwdog_checker (
  input logic       clk,
  input logic       rst,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       mouse_irq,
  input logic       kbd_irq,
  input logic       wdt_fire,
  input logic       kbd_rst_n,
  input logic [7:0] count,
  input logic       fired,
  input logic       route_en
);
  a_r12_fire_single: assert property (@(posedge clk) disable iff (rst)
    wdt_fire |=> !wdt_fire);

  a_r9_flag_with_fire: assert property (@(posedge clk) disable iff (rst)
    wdt_fire |-> fired);

  a_r9_no_refire: assert property (@(posedge clk) disable iff (rst)
    $past(fired) |-> !wdt_fire);

  a_r2_count_step: assert property (@(posedge clk) disable iff (rst)
    (!$past(bus_wr && bus_addr == 2'd1) && !$past(mouse_irq) && !$past(kbd_irq))
    |-> (count == $past(count) || count == $past(count) - 8'd1 || count == 8'd0));

  a_r11_route_only: assert property (@(posedge clk) disable iff (rst)
    $fell(kbd_rst_n) |-> $past(route_en));
endmodule

bind pwdog_top pwdog_checker u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .mouse_irq(mouse_irq), .kbd_irq(kbd_irq), .wdt_fire(wdt_fire),
  .kbd_rst_n(kbd_rst_n), .count(count), .fired(fired), .route_en(route_en)
);

// File: tb/tb_pwdog_top.sv
module tb_pwdog_top;
  localparam int CPS = 10;
  localparam int PW  = 4;
  localparam logic [1:0] A_CTRL = 2'd0, A_TMO = 2'd1, A_STAT = 2'd2;

  // table: timeout value, 60 s unit select, expected cycles to fire
  localparam int NV = 5;
  localparam int VEC [NV][3] = '{
    '{1, 0, 10}, '{3, 0, 30}, '{7, 0, 70}, '{1, 1, 600}, '{2, 1, 1200}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic mouse_irq = 1'b0, kbd_irq = 1'b0, kbc_p20 = 1'b0;
  logic wdt_fire, kbd_rst_n;
  logic [3:0] irq_code;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pwdog_top #(.CLKS_PER_SEC(CPS), .PULSE_CYCLES(PW)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mouse_irq(mouse_irq), .kbd_irq(kbd_irq), .kbc_p20(kbc_p20),
    .wdt_fire(wdt_fire), .kbd_rst_n(kbd_rst_n), .irq_code(irq_code)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wait_fire(input int limit, output int n, output bit seen);
    n = 0; seen = 1'b0;
    while (n < limit && !seen) begin
      @(negedge clk);
      n++;
      seen = wdt_fire;
    end
  endtask

  task automatic pulse_mouse(); mouse_irq = 1'b1; @(negedge clk); mouse_irq = 1'b0; endtask
  task automatic pulse_kbd();   kbd_irq = 1'b1;   @(negedge clk); kbd_irq = 1'b0;   endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual 1 expected 0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n, lowc;
    bit seen;

    repeat (5) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd(A_CTRL, d); check("R1 ctrl", d, 0);
    rd(A_TMO, d);  check("R1 tmo", d, 0);
    rd(A_STAT, d); check("R1 stat", d, 0);
    check("R1 fire", wdt_fire, 0);
    check("R1 rst_n", kbd_rst_n, 1);

    // R2/R3 table walk
    for (int i = 0; i < NV; i++) begin
      wr(A_CTRL, VEC[i][1] ? 8'h08 : 8'h00);
      wr(A_TMO, 8'(VEC[i][0]));
      wait_fire(VEC[i][2] + 50, n, seen);
      check(VEC[i][1] ? "R3 fire latency" : "R2 fire latency", n, VEC[i][2]);
      wr(A_STAT, 8'h00);
    end
    wr(A_CTRL, 8'h00);

    // R5 remaining count
    wr(A_TMO, 8'd5);
    repeat (24) @(negedge clk);
    rd(A_TMO, d); check("R5 remaining", d, 3);
    // R4 stop by zero
    wr(A_TMO, 8'd0);
    wait_fire(100, n, seen);
    check("R4 no fire", seen, 0);
    rd(A_TMO, d); check("R4 reads zero", d, 0);

    // R6 mouse reload
    wr(A_STAT, 8'h80);
    wr(A_TMO, 8'd3);
    repeat (24) @(negedge clk);
    pulse_mouse();
    wait_fire(80, n, seen);
    check("R6 mouse reload", n, 30);
    // R7 keyboard pulse ignored while only mouse enabled
    wr(A_STAT, 8'h80);
    wr(A_TMO, 8'd3);
    repeat (24) @(negedge clk);
    pulse_kbd();
    wait_fire(80, n, seen);
    check("R7 kbd ignored", n, 5);
    // R7 keyboard reload
    wr(A_STAT, 8'h40);
    wr(A_TMO, 8'd3);
    repeat (24) @(negedge clk);
    pulse_kbd();
    wait_fire(80, n, seen);
    check("R7 kbd reload", n, 30);
    // R6 mouse ignored while disabled
    wr(A_STAT, 8'h00);
    wr(A_TMO, 8'd3);
    repeat (24) @(negedge clk);
    pulse_mouse();
    wait_fire(80, n, seen);
    check("R6 mouse ignored", n, 5);
    wr(A_STAT, 8'h00);

    // R8 force with R11 routing
    wr(A_CTRL, 8'h02);
    wr(A_STAT, 8'h20);
    check("R8 force fire", wdt_fire, 1);
    check("R11 pin low", kbd_rst_n, 0);
    lowc = 1;
    @(negedge clk);
    check("R12 fire one cycle", wdt_fire, 0);
    while (!kbd_rst_n && lowc < 50) begin
      lowc++;
      @(negedge clk);
    end
    check("R11 pulse width", lowc, PW);
    rd(A_STAT, d); check("R8 R9 status after force", d, 8'h10);

    // R9 sticky blocks refire
    wr(A_TMO, 8'd2);
    wait_fire(40, n, seen);
    check("R9 no refire on expiry", seen, 0);
    wr(A_STAT, 8'h30);
    check("R9 no refire on force", wdt_fire, 0);
    check("R9 pin stays high", kbd_rst_n, 1);
    rd(A_STAT, d); check("R9 flag kept", d, 8'h10);
    wr(A_STAT, 8'h00);
    rd(A_STAT, d); check("R9 flag cleared", d, 0);

    // R11 routing off
    wr(A_CTRL, 8'h00);
    wr(A_STAT, 8'h20);
    check("R11 fire no route", wdt_fire, 1);
    check("R11 pin high no route", kbd_rst_n, 1);
    wr(A_STAT, 8'h00);

    // R10 keyboard-controller line
    kbc_p20 = 1'b1;
    wait_fire(10, n, seen);
    check("R10 p20 ignored", seen, 0);
    wr(A_CTRL, 8'h04);
    wait_fire(5, n, seen);
    check("R10 p20 fire", n, 1);
    kbc_p20 = 1'b0;
    wr(A_CTRL, 8'h00);
    wr(A_STAT, 8'h00);

    // R12 irq code
    wr(A_STAT, 8'h02);
    check("R12 irq code 2", irq_code, 2);
    rd(A_STAT, d); check("R12 stat readback", d, 8'h02);
    wr(A_STAT, 8'h0F);
    check("R12 irq code 15", irq_code, 15);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule